// File: doc/BRIEF.md
# Write-Only Two-Wire Register Target

This block is a receive-only target on a two-wire serial bus (I2C standard mode). It sits behind two-flop synchronizers on a fast system clock and watches the serial clock and data lines. It recognises bus START and STOP conditions and checks the first byte of each transfer against its own 7-bit address. That address is a fixed five-bit prefix followed by two bits taken from strap pins. It then takes a register pointer byte and stores every byte after it into a 32-entry by 8-bit register file.

The pointer steps by one after each stored byte and wraps from the last entry back to the first, so a long burst overwrites earlier entries. The target pulls the data line low only through an output-enable signal, which suits an open-drain pad. Read requests are refused by leaving the line released. The rest of the chip sees the stored values through a combinational parallel read port.

Top module: `i2cw_target`

## Requirements
- R1: A high-to-low change of SDA while SCL is high (START) starts address reception from any state, including in the middle of a transfer (repeated START).
- R2: A first byte, sent MSB first, of the form 0b00100 followed by strap_i[1] and strap_i[0] and then a direction bit of 0 is acknowledged: sda_oe_o is 1 during the ninth SCL clock.
- R3: A first byte whose top seven bits differ from that form, or whose direction bit is 1, gets no acknowledge. All traffic is then ignored, with no acknowledge and no register write, until the next START.
- R4: The second byte of a matched transfer is acknowledged, and its low five bits load the register pointer. Its top three bits are ignored.
- R5: Each byte after the pointer byte is received MSB first, acknowledged, and written to the register the pointer selects.
- R6: After each stored byte the 5-bit pointer increments by one, and it wraps from 0x1F to 0x00.
- R7: A low-to-high change of SDA while SCL is high (STOP) returns the target to idle and keeps all stored values. Clocked bytes without a new START are then ignored and not acknowledged.
- R8: sda_oe_o changes only while SCL is low. It is asserted from the SCL falling edge that ends bit 0 until the next SCL falling edge.
- R9: Synchronous active-high reset clears all 32 registers to 0x00 and releases sda_oe_o.
- R10: rd_data_o shows, without any clock delay, the register selected by rd_addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| strap_i | input | 2 | Strapped low two bits of the target address |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| rd_addr_i | input | 5 | Register index for the parallel read port |
| rd_data_o | output | 8 | Contents of the selected register |

## Verification
A wrong bit count or phase shows up within one byte time as an acknowledge pulse in the wrong bit slot, or as a missing one. A wrong pointer shows up on the read port as data stored in a neighbouring entry, or at a wrong wrap position. A target stuck in the ignore state or the idle state shows up as a NACK on the very next address byte. A filter that lets a stray write through after a refused address or after STOP shows up on the read port as soon as that byte's last bit has been clocked in.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    localparam int REG_AW = 5;
    localparam int DW     = 8;
    localparam int REG_N  = 1 << REG_AW;
    localparam int BIT_CW = $clog2(DW + 1);
    localparam logic [4:0] DEV_PREFIX = 5'b00100;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_SKIP
    } link_st_e;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_PTR,
        PH_DATA
    } phase_e;

    typedef struct packed {
        logic              en;
        logic [REG_AW-1:0] addr;
        logic [DW-1:0]     data;
    } wr_req_t;

    function automatic logic dev_write_hit(input logic [DW-1:0] b,
                                           input logic [1:0]    strap);
        return (b[7:3] == DEV_PREFIX) && (b[2:1] == strap) && !b[0];
    endfunction

endpackage

// File: rtl/i2cw_sync_edge.sv
module i2cw_sync_edge #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
            last  <= RST_VAL;
        end else begin
            chain <= {chain[STAGES-2:0], d};
            last  <= chain[STAGES-1];
        end
    end

    assign lvl  = chain[STAGES-1];
    assign rise = lvl & ~last;
    assign fall = ~lvl & last;
endmodule

// File: rtl/i2cw_regfile.sv
module i2cw_regfile
    import i2cw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [DW-1:0]     rd_data
);
    logic [REG_N-1:0][DW-1:0] mem;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem <= '0;
        end else if (wr.en) begin
            mem[wr.addr] <= wr.data;
        end
    end

    assign rd_data = mem[rd_addr];

    // R5/R7: contents move only on a write request
    a_r7_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !wr.en |=> $stable(mem));

    // R5: a write lands at the requested entry
    a_r5_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr.en |=> mem[$past(wr.addr)] == $past(wr.data));
endmodule

// File: rtl/i2cw_link.sv
module i2cw_link
    import i2cw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_lvl,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       sda_lvl,
    input  logic       sda_rise,
    input  logic       sda_fall,
    input  logic [1:0] strap,
    output logic       sda_oe,
    output wr_req_t    wr
);
    link_st_e          st;
    phase_e            ph;
    logic [BIT_CW-1:0] cnt;
    logic [DW-1:0]     shreg;
    logic [REG_AW-1:0] ptr;
    logic              start_det, stop_det, byte_end;

    assign start_det = sda_fall & scl_lvl;
    assign stop_det  = sda_rise & scl_lvl;
    assign byte_end  = scl_fall && (cnt == BIT_CW'(DW));

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            ph     <= PH_DEV;
            cnt    <= '0;
            shreg  <= '0;
            ptr    <= '0;
            sda_oe <= 1'b0;
        end else if (start_det) begin
            st     <= ST_RX;
            ph     <= PH_DEV;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else if (stop_det) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            unique case (st)
                ST_RX: begin
                    if (scl_rise && cnt != BIT_CW'(DW)) begin
                        shreg <= {shreg[DW-2:0], sda_lvl};
                        cnt   <= cnt + 1'b1;
                    end else if (byte_end) begin
                        unique case (ph)
                            PH_DEV: begin
                                if (dev_write_hit(shreg, strap)) begin
                                    sda_oe <= 1'b1;
                                    st     <= ST_ACK;
                                    ph     <= PH_PTR;
                                end else begin
                                    st     <= ST_SKIP;
                                end
                            end
                            PH_PTR: begin
                                ptr    <= shreg[REG_AW-1:0];
                                sda_oe <= 1'b1;
                                st     <= ST_ACK;
                                ph     <= PH_DATA;
                            end
                            default: begin
                                ptr    <= ptr + 1'b1;
                                sda_oe <= 1'b1;
                                st     <= ST_ACK;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                        st     <= ST_RX;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        wr.en   = (st == ST_RX) && byte_end && (ph == PH_DATA)
                  && !start_det && !stop_det;
        wr.addr = ptr;
        wr.data = shreg;
    end

    a_r8_oe_rises_scl_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_lvl);

    a_r8_oe_falls_scl_low: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_oe) |-> !scl_lvl);

    a_r3_skip_is_silent: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SKIP) |-> (!sda_oe && !wr.en));

    a_r7_stop_to_idle: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> (st == ST_IDLE && !sda_oe));

    a_r1_start_restarts: assert property (@(posedge clk) disable iff (rst)
        start_det |=> (st == ST_RX && ph == PH_DEV && cnt == '0));

    a_r6_ptr_steps: assert property (@(posedge clk) disable iff (rst)
        wr.en |=> ptr == $past(ptr) + 1'b1);
endmodule

// File: rtl/i2cw_target.sv
module i2cw_target
    import i2cw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        strap_i,
    output logic              sda_oe_o,
    input  logic [REG_AW-1:0] rd_addr_i,
    output logic [DW-1:0]     rd_data_o
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw, lvl, rise, fall;
    wr_req_t          wr;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_sync
        i2cw_sync_edge #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (raw[g]),
            .lvl (lvl[g]),
            .rise(rise[g]),
            .fall(fall[g])
        );
    end

    i2cw_link u_link (
        .clk     (clk),
        .rst     (rst),
        .scl_lvl (lvl[0]),
        .scl_rise(rise[0]),
        .scl_fall(fall[0]),
        .sda_lvl (lvl[1]),
        .sda_rise(rise[1]),
        .sda_fall(fall[1]),
        .strap   (strap_i),
        .sda_oe  (sda_oe_o),
        .wr      (wr)
    );

    i2cw_regfile u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .rd_addr(rd_addr_i),
        .rd_data(rd_data_o)
    );
endmodule

// File: tb/i2cw_target_bench.sv
module i2cw_target_bench;
    localparam int Q = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'b10;
    logic [4:0] rd_addr = '0;
    logic       sda_oe;
    logic [7:0] rd_data;
    logic       sda_line;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model [32];
    int oe_bad = 0;
    logic oe_q = 1'b0;
    bit done = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    i2cw_target u_i2cw_target (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
        .strap_i(strap), .sda_oe_o(sda_oe),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data)
    );

    // R8 monitor: enable may change only while SCL is low
    always @(negedge clk) begin
        if (!rst && sda_oe !== oe_q && scl !== 1'b0) oe_bad++;
        oe_q <= sda_oe;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl = 1'b1; wq();
        sda_m = 1'b0; wq(); scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0;
        end
        sda_m = 1'b1; wq(); scl = 1'b1; wq();
        ack = (sda_line == 1'b0);
        wq(); scl = 1'b0; wq();
    endtask

    task automatic check_regs(input string req);
        for (int a = 0; a < 32; a++) begin
            rd_addr = 5'(a); #1;
            check(rd_data == model[a], req, rd_data, model[a]);
        end
    endtask

    function automatic logic [7:0] dev_byte(input logic [1:0] s, input bit rd);
        return {5'b00100, s, rd};
    endfunction

    task automatic t_reset();
        check(sda_oe == 1'b0, "R9 oe after reset", sda_oe, 0);
        check_regs("R9/R10 reset contents");
    endtask

    task automatic t_single_write();
        bit ack;
        bus_start();
        send_byte(dev_byte(strap, 1'b0), ack); check(ack, "R2 address ack", ack, 1);
        send_byte(8'hE5, ack);                 check(ack, "R4 pointer ack", ack, 1);
        send_byte(8'hA5, ack);                 check(ack, "R5 data ack", ack, 1);
        check(sda_oe == 1'b0, "R8 released after ack", sda_oe, 0);
        bus_stop();
        model[5] = 8'hA5;
        check_regs("R4/R5 single write, top pointer bits ignored");
    endtask

    task automatic t_wrap_burst();
        bit ack;
        bus_start();
        send_byte(dev_byte(strap, 1'b0), ack);
        send_byte(8'h1E, ack);
        send_byte(8'h11, ack); check(ack, "R5 burst ack 1", ack, 1);
        send_byte(8'h22, ack); check(ack, "R5 burst ack 2", ack, 1);
        send_byte(8'h33, ack); check(ack, "R6 ack after wrap", ack, 1);
        send_byte(8'h44, ack);
        bus_stop();
        model[30] = 8'h11; model[31] = 8'h22; model[0] = 8'h33; model[1] = 8'h44;
        check_regs("R6 pointer wrap 1F to 00");
    endtask

    task automatic t_refused(input logic [7:0] first, input string req);
        bit ack;
        bus_start();
        send_byte(first, ack);  check(!ack, {req, " no ack on address"}, ack, 0);
        send_byte(8'h03, ack);  check(!ack, {req, " ignored pointer"}, ack, 0);
        send_byte(8'h77, ack);  check(!ack, {req, " ignored data"}, ack, 0);
        bus_stop();
        check_regs({req, " no write"});
    endtask

    task automatic t_repeated_start();
        bit ack;
        bus_start();
        send_byte(dev_byte(strap, 1'b0), ack);
        send_byte(8'h08, ack);
        send_byte(8'h5A, ack);
        bus_start();
        send_byte(dev_byte(strap, 1'b0), ack); check(ack, "R1 address ack after repeated START", ack, 1);
        send_byte(8'h09, ack);
        send_byte(8'hC3, ack); check(ack, "R1 data ack after repeated START", ack, 1);
        bus_stop();
        model[8] = 8'h5A; model[9] = 8'hC3;
        check_regs("R1 repeated START");
    endtask

    task automatic t_stop_then_noise();
        bit ack;
        bus_start();
        send_byte(dev_byte(strap, 1'b0), ack);
        send_byte(8'h0A, ack);
        bus_stop();
        scl = 1'b0; wq();
        send_byte(8'h99, ack); check(!ack, "R7 no ack after STOP", ack, 0);
        send_byte(8'h98, ack); check(!ack, "R7 still idle", ack, 0);
        scl = 1'b1; wq(); bus_stop();
        check_regs("R7 values kept, no write after STOP");
    endtask

    task automatic t_strap_change();
        bit ack;
        strap = 2'b01; wq();
        bus_start();
        send_byte(dev_byte(2'b01, 1'b0), ack); check(ack, "R2 ack with new strap", ack, 1);
        send_byte(8'h10, ack);
        send_byte(8'h6B, ack);
        bus_stop();
        model[16] = 8'h6B;
        check_regs("R2 strap-selected address writes");
    endtask

    initial begin
        for (int a = 0; a < 32; a++) model[a] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_reset();
        t_single_write();
        t_wrap_burst();
        t_refused(dev_byte(strap, 1'b1), "R3 read request");
        t_refused(dev_byte(~strap, 1'b0), "R3 strap mismatch");
        t_refused(8'h44, "R3 prefix mismatch");
        t_repeated_start();
        t_stop_then_noise();
        t_strap_change();
        check(oe_bad == 0, "R8 enable changes only with SCL low", oe_bad, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule